// File: doc/BRIEF.md
# Bus master bridge with transfer watchdog

This block sits between a simple processor-side load/store port and a classic single-transfer shared bus. The processor presents an address, write data, an access size and a direction together with a one-cycle request strobe. The bridge captures the request, works out which byte lanes the access touches, shifts write data onto those lanes and drives a bus cycle until the target answers with an acknowledge or an error. Only one transfer is ever outstanding; while it runs the bridge raises `busy` and drops any new request.

A transfer ends in one of three ways: acknowledge (normal completion, read data returned right-justified), error (access fault) or expiry of a watchdog that limits how many cycles the bus cycle may stay open (access fault). Faults are reported separately for loads and stores. Accesses that are not naturally aligned never reach the bus and are answered with a fault. The completion report passes through a configurable chain of 0, 1 or 2 register stages before it reaches the processor.

Top module: `bus_master_bridge`

## Requirements
- R1: After reset, `bus_cyc`, `bus_stb`, `busy`, `rsp_done`, `rsp_load_fault` and `rsp_store_fault` are all low.
- R2: A request (`req_valid` high while `busy` is low) raises `bus_cyc` and `bus_stb` in the next cycle with `bus_adr` equal to the captured `req_addr` and `bus_we` equal to `req_we`; address, data, lane selects and direction stay constant for the whole bus cycle even if the request inputs change.
- R3: Size code 0 (byte) selects lane `1 << addr[1:0]`, code 1 (halfword) selects `3 << addr[1:0]`, codes 2 and 3 (word) select all four lanes; `bus_dat_w` is the write data shifted left by `8*addr[1:0]` with zeros elsewhere.
- R4: A halfword with `addr[0]=1` or a word with `addr[1:0]!=0` starts no bus cycle; it is treated as a transfer that terminates in the cycle after acceptance and is reported as a fault of its direction.
- R5: An acknowledge during a bus cycle ends it: `bus_cyc` and `bus_stb` are low in the following cycle, no fault is reported, and a read returns the addressed lanes shifted down to bit 0 and zero-extended (writes return zero).
- R6: An error during a bus cycle ends it the same way and reports `rsp_load_fault` for a read or `rsp_store_fault` for a write, with `rsp_rdata` zero; error wins over an acknowledge in the same cycle.
- R7: A bus cycle with no reply stays open for exactly `TIMEOUT` cycles and is then closed with a fault of its direction; an acknowledge in the last of those cycles completes normally.
- R8: `rsp_done` is a one-cycle pulse appearing `REG_STAGES` cycles after the terminating cycle (the same cycle when `REG_STAGES` is 0); the fault outputs are high only together with `rsp_done`.
- R9: `busy` is high from the cycle after acceptance up to and including the `rsp_done` cycle; requests while `busy` is high are ignored and do not start a later transfer.
- R10: Acknowledge or error while no bus cycle is open has no effect: no `rsp_done`, no fault and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_we | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data, right-justified |
| busy | output | 1 | Transfer or response in flight |
| rsp_done | output | 1 | Completion pulse |
| rsp_rdata | output | 32 | Read data, right-justified, zero-extended |
| rsp_load_fault | output | 1 | Read ended by error, timeout or misalignment |
| rsp_store_fault | output | 1 | Write ended by error, timeout or misalignment |
| bus_adr | output | ADDR_W | Bus address |
| bus_dat_w | output | 32 | Bus write data on the selected lanes |
| bus_dat_r | input | 32 | Bus read data |
| bus_sel | output | 4 | Byte lane selects |
| bus_we | output | 1 | Bus write enable |
| bus_stb | output | 1 | Bus strobe |
| bus_cyc | output | 1 | Bus cycle |
| bus_ack | input | 1 | Target acknowledge |
| bus_err | input | 1 | Target error |

## Verification
On every cycle the checker confirms that the bus cycle only opens after an accepted request, that its address, data, selects and direction never move while it is open, that the lane selects always cover one, two or four lanes, that acknowledge or error closes it in the next cycle, that it never stays open past the watchdog limit, that completion is a single pulse and that faults appear only with it. Only the directed scenarios can show the values themselves: the exact lane pattern and shifted data per size and offset, the right-justified read data, the fault direction, the boundary where an acknowledge in the last permitted cycle beats the watchdog, the response latency through the stage chain, and that ignored requests and stray replies leave no trace.

// File: rtl/bmb_pkg.sv
package bmb_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned LANES  = DATA_W / 8;
  localparam int unsigned OFF_W  = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUS  = 2'd1,
    ST_MIS  = 2'd2
  } state_e;

  typedef struct packed {
    logic              valid;
    logic              ld_fault;
    logic              st_fault;
    logic [DATA_W-1:0] rdata;
  } rsp_t;
endpackage

// File: rtl/bmb_rst_sync.sv
module bmb_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_out = sync_q;
endmodule

// File: rtl/bmb_lanes.sv
module bmb_lanes
  import bmb_pkg::*;
(
  input  size_e             req_size,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [LANES-1:0]  req_sel,
  output logic [DATA_W-1:0] req_wlane,
  output logic              req_misaligned,
  input  size_e             rsp_size,
  input  logic [OFF_W-1:0]  rsp_off,
  input  logic [DATA_W-1:0] rsp_raw,
  output logic [DATA_W-1:0] rsp_just
);
  logic [LANES-1:0]  req_span;
  logic [LANES-1:0]  rsp_span;
  logic [DATA_W-1:0] rsp_shifted;

  // lanes covered by an access placed at offset zero
  always_comb begin
    unique case (req_size)
      SZ_BYTE: req_span = LANES'(1);
      SZ_HALF: req_span = LANES'(3);
      default: req_span = '1;
    endcase
  end

  always_comb begin
    unique case (rsp_size)
      SZ_BYTE: rsp_span = LANES'(1);
      SZ_HALF: rsp_span = LANES'(3);
      default: rsp_span = '1;
    endcase
  end

  // natural alignment rule per access size
  always_comb begin
    unique case (req_size)
      SZ_BYTE: req_misaligned = 1'b0;
      SZ_HALF: req_misaligned = req_off[0];
      default: req_misaligned = |req_off;
    endcase
  end

  assign req_sel     = req_span << req_off;
  assign req_wlane   = req_wdata << {req_off, 3'b000};
  assign rsp_shifted = rsp_raw >> {rsp_off, 3'b000};

  // keep only the lanes the access owns, zero-extend the rest
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign rsp_just[8*i +: 8] = rsp_span[i] ? rsp_shifted[8*i +: 8] : 8'h00;
  end
endmodule

// File: rtl/bmb_watchdog.sv
module bmb_watchdog #(
  parameter int unsigned LIMIT = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  // counts cycles of an open bus cycle, cleared whenever it is closed
  always_comb begin
    if (run) cnt_d = cnt_q + CW'(1);
    else     cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expire = run && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/bmb_rsp_stage.sv
module bmb_rsp_stage
  import bmb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  rsp_t d,
  output rsp_t q
);
  logic              valid_q;
  logic              ld_q;
  logic              st_q;
  logic [DATA_W-1:0] rdata_q;
  logic              data_en;

  assign data_en = d.valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      ld_q    <= 1'b0;
      st_q    <= 1'b0;
    end else begin
      valid_q <= d.valid;
      ld_q    <= d.ld_fault;
      st_q    <= d.st_fault;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (data_en) rdata_q <= d.rdata;
  end

  assign q.valid    = valid_q;
  assign q.ld_fault = ld_q;
  assign q.st_fault = st_q;
  assign q.rdata    = rdata_q;
endmodule

// File: rtl/bus_master_bridge.sv
module bus_master_bridge
  import bmb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int REG_STAGES = 2,
  parameter int TIMEOUT    = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_load_fault,
  output logic              rsp_store_fault,
  output logic [ADDR_W-1:0] bus_adr,
  output logic [DATA_W-1:0] bus_dat_w,
  input  logic [DATA_W-1:0] bus_dat_r,
  output logic [LANES-1:0]  bus_sel,
  output logic              bus_we,
  output logic              bus_stb,
  output logic              bus_cyc,
  input  logic              bus_ack,
  input  logic              bus_err
);
  logic rst_sync_n;

  bmb_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  state_e            st_q, st_d;
  logic [ADDR_W-1:0] adr_q;
  logic [DATA_W-1:0] wd_q;
  logic [LANES-1:0]  sel_q;
  logic              we_q;
  size_e             size_q;

  logic [LANES-1:0]  sel_new;
  logic [DATA_W-1:0] wlane_new;
  logic              mis_new;
  logic [DATA_W-1:0] rd_just;

  logic busy_w;
  logic accept;
  logic cyc_w;
  logic tmo_exp;
  logic term;
  logic in_flight;
  logic fault;
  rsp_t head;
  rsp_t pipe [0:REG_STAGES];

  bmb_lanes u_lanes (
    .req_size       (size_e'(req_size)),
    .req_off        (req_addr[OFF_W-1:0]),
    .req_wdata      (req_wdata),
    .req_sel        (sel_new),
    .req_wlane      (wlane_new),
    .req_misaligned (mis_new),
    .rsp_size       (size_q),
    .rsp_off        (adr_q[OFF_W-1:0]),
    .rsp_raw        (bus_dat_r),
    .rsp_just       (rd_just)
  );

  bmb_watchdog #(.LIMIT(TIMEOUT)) u_wdog (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .run    (cyc_w),
    .expire (tmo_exp)
  );

  assign accept = req_valid && !busy_w;
  assign cyc_w  = (st_q == ST_BUS);
  assign term   = cyc_w && (bus_ack || bus_err || tmo_exp);

  // next-state logic
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (accept) st_d = mis_new ? ST_MIS : ST_BUS;
      ST_BUS:  if (term)   st_d = ST_IDLE;
      ST_MIS:              st_d = ST_IDLE;
      default:             st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) st_q <= ST_IDLE;
    else             st_q <= st_d;
  end

  // request capture, enabled only on acceptance
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      adr_q  <= '0;
      wd_q   <= '0;
      sel_q  <= '0;
      we_q   <= 1'b0;
      size_q <= SZ_BYTE;
    end else if (accept) begin
      adr_q  <= req_addr;
      wd_q   <= wlane_new;
      sel_q  <= sel_new;
      we_q   <= req_we;
      size_q <= size_e'(req_size);
    end
  end

  // completion entry: error beats acknowledge, acknowledge beats expiry
  always_comb begin
    fault         = (st_q == ST_MIS) || (cyc_w && (bus_err || (tmo_exp && !bus_ack)));
    head.valid    = term || (st_q == ST_MIS);
    head.ld_fault = fault && !we_q;
    head.st_fault = fault && we_q;
    head.rdata    = (cyc_w && bus_ack && !bus_err && !we_q) ? rd_just : '0;
  end

  assign pipe[0] = head;

  for (genvar g = 0; g < REG_STAGES; g++) begin : g_stage
    bmb_rsp_stage u_stg (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .d     (pipe[g]),
      .q     (pipe[g+1])
    );
  end

  always_comb begin
    in_flight = 1'b0;
    for (int i = 1; i <= REG_STAGES; i++) in_flight = in_flight | pipe[i].valid;
  end

  assign busy_w = (st_q != ST_IDLE) || in_flight;

  assign busy            = busy_w;
  assign rsp_done        = pipe[REG_STAGES].valid;
  assign rsp_rdata       = pipe[REG_STAGES].rdata;
  assign rsp_load_fault  = pipe[REG_STAGES].ld_fault;
  assign rsp_store_fault = pipe[REG_STAGES].st_fault;

  assign bus_adr   = adr_q;
  assign bus_dat_w = wd_q;
  assign bus_sel   = sel_q;
  assign bus_we    = we_q;
  assign bus_cyc   = cyc_w;
  assign bus_stb   = cyc_w;
endmodule

// File: rtl/bmb_chk.sv
module bmb_chk #(
  parameter int ADDR_W  = 32,
  parameter int TIMEOUT = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              busy,
  input logic              rsp_done,
  input logic              rsp_load_fault,
  input logic              rsp_store_fault,
  input logic [ADDR_W-1:0] bus_adr,
  input logic [31:0]       bus_dat_w,
  input logic [3:0]        bus_sel,
  input logic              bus_we,
  input logic              bus_stb,
  input logic              bus_cyc,
  input logic              bus_ack,
  input logic              bus_err
);
  int open_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       open_cnt <= 0;
    else if (bus_cyc) open_cnt <= open_cnt + 1;
    else              open_cnt <= 0;
  end

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && $past(bus_cyc)) |-> ($stable(bus_adr) && $stable(bus_sel) && $stable(bus_we) && $stable(bus_dat_w)));

  // R2
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_cyc) |-> ($past(req_valid) && !$past(busy)));

  // R3
  lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc |-> ($countones(bus_sel) == 1 || $countones(bus_sel) == 2 || $countones(bus_sel) == 4));

  // R5
  close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && (bus_ack || bus_err)) |=> (!bus_cyc && !bus_stb));

  // R7
  limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc |-> (open_cnt < TIMEOUT));

  // R8
  fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_load_fault || rsp_store_fault) |-> (rsp_done && !(rsp_load_fault && rsp_store_fault)));

  // R8
  pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  // R9
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc |-> busy);
endmodule

bind bus_master_bridge bmb_chk #(.ADDR_W(ADDR_W), .TIMEOUT(TIMEOUT)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .req_valid       (req_valid),
  .busy            (busy),
  .rsp_done        (rsp_done),
  .rsp_load_fault  (rsp_load_fault),
  .rsp_store_fault (rsp_store_fault),
  .bus_adr         (bus_adr),
  .bus_dat_w       (bus_dat_w),
  .bus_sel         (bus_sel),
  .bus_we          (bus_we),
  .bus_stb         (bus_stb),
  .bus_cyc         (bus_cyc),
  .bus_ack         (bus_ack),
  .bus_err         (bus_err)
);

// File: tb/sim_bus_master_bridge.sv
module sim_bus_master_bridge;
  localparam int STG = 2;
  localparam int TMO = 15;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_we;
  logic [1:0]  req_size;
  logic [31:0] req_addr, req_wdata;
  logic        busy, rsp_done, rsp_load_fault, rsp_store_fault;
  logic [31:0] rsp_rdata;
  logic [31:0] bus_adr, bus_dat_w, bus_dat_r;
  logic [3:0]  bus_sel;
  logic        bus_we, bus_stb, bus_cyc, bus_ack, bus_err;

  int n_chk = 0;
  int n_fail = 0;

  int          r_cyc_n, r_done_n, r_lat, r_cyc0, r_busy0, r_stable, r_we;
  logic [31:0] r_adr, r_dat, r_rdata;
  logic [3:0]  r_sel;
  logic        r_lf, r_sf, r_busy_done;

  always #2 clk = ~clk;

  bus_master_bridge #(.ADDR_W(32), .REG_STAGES(STG), .TIMEOUT(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .rsp_done(rsp_done),
    .rsp_rdata(rsp_rdata), .rsp_load_fault(rsp_load_fault), .rsp_store_fault(rsp_store_fault),
    .bus_adr(bus_adr), .bus_dat_w(bus_dat_w), .bus_dat_r(bus_dat_r), .bus_sel(bus_sel),
    .bus_we(bus_we), .bus_stb(bus_stb), .bus_cyc(bus_cyc), .bus_ack(bus_ack), .bus_err(bus_err)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // kind: 0 ack, 1 error, 2 no reply, 3 ack and error together
  task automatic xfer(input bit we, input logic [1:0] sz, input logic [31:0] addr,
                      input logic [31:0] wdata, input int kind, input int wait_n,
                      input logic [31:0] slave_rd);
    int tick, term_tick, done_tick;
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_size = sz; req_addr = addr; req_wdata = wdata;
    @(negedge clk);
    req_valid = 1'b0; req_addr = 32'h5A5A_0000; req_wdata = 32'hFFFF_FFFF; req_we = ~we;
    tick = 0; term_tick = -1; done_tick = -1;
    r_cyc_n = 0; r_done_n = 0; r_stable = 1; r_rdata = 'x; r_lf = 1'b0; r_sf = 1'b0;
    r_busy0 = int'(busy); r_cyc0 = int'(bus_cyc);
    r_adr = bus_adr; r_sel = bus_sel; r_dat = bus_dat_w; r_we = int'(bus_we);
    for (int it = 0; it < 60; it++) begin
      if (rsp_done) begin
        r_done_n++; done_tick = tick; r_rdata = rsp_rdata;
        r_lf = rsp_load_fault; r_sf = rsp_store_fault; r_busy_done = busy;
      end
      if (bus_cyc) begin
        r_cyc_n++;
        if (bus_adr !== r_adr || bus_sel !== r_sel || bus_dat_w !== r_dat) r_stable = 0;
        if (kind == 2) term_tick = tick;
        else if (r_cyc_n == wait_n + 1) begin
          bus_ack = (kind == 0 || kind == 3);
          bus_err = (kind == 1 || kind == 3);
          bus_dat_r = slave_rd;
          term_tick = tick;
        end
      end else if (tick == 0) term_tick = 0;
      @(negedge clk);
      bus_ack = 1'b0; bus_err = 1'b0; bus_dat_r = 32'h0BAD_0BAD;
      tick++;
      if (done_tick >= 0 && tick > done_tick + 2) break;
    end
    r_lat = done_tick - term_tick;
  endtask

  task automatic t_reset();
    chk("R1", "cyc", {31'b0, bus_cyc}, 32'd0);
    chk("R1", "stb", {31'b0, bus_stb}, 32'd0);
    chk("R1", "busy", {31'b0, busy}, 32'd0);
    chk("R1", "done", {31'b0, rsp_done}, 32'd0);
    chk("R1", "faults", {30'b0, rsp_load_fault, rsp_store_fault}, 32'd0);
  endtask

  task automatic t_word_write();
    xfer(1'b1, 2'd2, 32'h1000_0008, 32'hA1B2_C3D4, 0, 0, 32'h0);
    chk("R2", "cyc after accept", r_cyc0, 1);
    chk("R2", "adr", r_adr, 32'h1000_0008);
    chk("R2", "we", r_we, 1);
    chk("R2", "stable", r_stable, 1);
    chk("R3", "word sel", {28'b0, r_sel}, 32'hF);
    chk("R3", "word data", r_dat, 32'hA1B2_C3D4);
    chk("R5", "cyc length", r_cyc_n, 1);
    chk("R5", "no fault", {30'b0, r_lf, r_sf}, 32'd0);
    chk("R5", "write rdata zero", r_rdata, 32'd0);
    chk("R8", "latency", r_lat, STG);
    chk("R8", "one pulse", r_done_n, 1);
    chk("R9", "busy during", r_busy0, 1);
    chk("R9", "busy at done", {31'b0, r_busy_done}, 32'd1);
    chk("R9", "idle after", {31'b0, busy}, 32'd0);
  endtask

  task automatic t_byte_reads();
    for (int off = 0; off < 4; off++) begin
      xfer(1'b0, 2'd0, 32'h2000_0000 + off, 32'h0, 0, 2, 32'h1122_3344);
      chk("R3", "byte sel", {28'b0, r_sel}, 32'd1 << off);
      chk("R5", "byte rdata", r_rdata, (32'h1122_3344 >> (8 * off)) & 32'hFF);
      chk("R5", "cyc length wait2", r_cyc_n, 3);
      chk("R8", "latency", r_lat, STG);
    end
    xfer(1'b1, 2'd0, 32'h2000_0003, 32'h0000_00E7, 0, 0, 32'h0);
    chk("R3", "byte write data", r_dat, 32'hE700_0000);
  endtask

  task automatic t_halves();
    xfer(1'b1, 2'd1, 32'h3000_0002, 32'h0000_BEEF, 0, 1, 32'h0);
    chk("R3", "half sel", {28'b0, r_sel}, 32'hC);
    chk("R3", "half data", r_dat, 32'hBEEF_0000);
    xfer(1'b0, 2'd1, 32'h3000_0000, 32'h0, 0, 0, 32'hCAFE_1234);
    chk("R3", "half sel low", {28'b0, r_sel}, 32'h3);
    chk("R5", "half rdata", r_rdata, 32'h0000_1234);
    xfer(1'b0, 2'd3, 32'h3000_0004, 32'h0, 0, 0, 32'h8765_4321);
    chk("R3", "code3 sel", {28'b0, r_sel}, 32'hF);
    chk("R5", "code3 rdata", r_rdata, 32'h8765_4321);
  endtask

  task automatic t_misaligned();
    xfer(1'b0, 2'd1, 32'h4000_0001, 32'h0, 0, 0, 32'h0);
    chk("R4", "no cycle", r_cyc_n, 0);
    chk("R4", "load fault", {30'b0, r_lf, r_sf}, 32'd2);
    chk("R4", "latency", r_lat, STG);
    chk("R4", "one pulse", r_done_n, 1);
    xfer(1'b1, 2'd2, 32'h4000_0002, 32'h1234_5678, 0, 0, 32'h0);
    chk("R4", "no cycle word", r_cyc_n, 0);
    chk("R4", "store fault", {30'b0, r_lf, r_sf}, 32'd1);
  endtask

  task automatic t_error();
    xfer(1'b1, 2'd2, 32'h5000_0000, 32'h0F0F_0F0F, 1, 1, 32'h0);
    chk("R6", "err cyc length", r_cyc_n, 2);
    chk("R6", "store fault", {30'b0, r_lf, r_sf}, 32'd1);
    chk("R6", "latency", r_lat, STG);
    xfer(1'b0, 2'd2, 32'h5000_0004, 32'h0, 3, 0, 32'hFFFF_0000);
    chk("R6", "err beats ack", {30'b0, r_lf, r_sf}, 32'd2);
    chk("R6", "fault rdata zero", r_rdata, 32'd0);
  endtask

  task automatic t_timeout();
    xfer(1'b0, 2'd2, 32'h6000_0000, 32'h0, 2, 0, 32'h0);
    chk("R7", "open cycles", r_cyc_n, TMO);
    chk("R7", "load fault", {30'b0, r_lf, r_sf}, 32'd2);
    chk("R7", "latency", r_lat, STG);
    xfer(1'b1, 2'd2, 32'h6000_0004, 32'h1, 2, 0, 32'h0);
    chk("R7", "store fault", {30'b0, r_lf, r_sf}, 32'd1);
    xfer(1'b0, 2'd2, 32'h6000_0008, 32'h0, 0, TMO - 1, 32'h7777_AAAA);
    chk("R7", "last-cycle ack length", r_cyc_n, TMO);
    chk("R7", "last-cycle ack no fault", {30'b0, r_lf, r_sf}, 32'd0);
    chk("R7", "last-cycle ack data", r_rdata, 32'h7777_AAAA);
  endtask

  task automatic t_busy_ignore();
    int dones;
    dones = 0;
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_size = 2'd2; req_addr = 32'h7000_0010;
    @(negedge clk);
    req_addr = 32'h7100_0020; req_we = 1'b1;
    for (int k = 0; k < 3; k++) @(negedge clk);
    chk("R9", "adr kept while busy", bus_adr, 32'h7000_0010);
    chk("R9", "we kept while busy", {31'b0, bus_we}, 32'd0);
    bus_ack = 1'b1; bus_dat_r = 32'h0;
    @(negedge clk);
    bus_ack = 1'b0;
    for (int k = 0; k < 10; k++) begin
      if (rsp_done) begin dones++; req_valid = 1'b0; end
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk("R9", "single completion", dones, 1);
    for (int k = 0; k < 4; k++) begin
      chk("R9", "no second cycle", {31'b0, bus_cyc}, 32'd0);
      @(negedge clk);
    end
  endtask

  task automatic t_stray();
    int seen;
    seen = 0;
    @(negedge clk);
    bus_ack = 1'b1; bus_err = 1'b1;
    @(negedge clk);
    bus_ack = 1'b0; bus_err = 1'b0;
    for (int k = 0; k < 5; k++) begin
      if (rsp_done || rsp_load_fault || rsp_store_fault || busy) seen++;
      @(negedge clk);
    end
    chk("R10", "stray reply ignored", seen, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0; req_size = 2'd0;
    req_addr = '0; req_wdata = '0; bus_dat_r = '0; bus_ack = 1'b0; bus_err = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_word_write();
    t_byte_reads();
    t_halves();
    t_misaligned();
    t_error();
    t_timeout();
    t_busy_ignore();
    t_stray();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule